// File: doc/BRIEF.md
# March test controller with read-previous checking

This block is a built-in self-test sequencer for a word-wide synchronous memory. It runs a six-element March test in which a written cell's neighbour is read back straight after the write. In the third and fourth elements, each write to address i is followed at once by a read of the cell visited just before it: i-1 while ascending, i+1 while descending. A disturbance that toggles that neighbour is therefore caught before a later write to the same neighbour can hide it.

The controller drives address, write enable, read enable and write data. It takes read data back with a one-cycle latency and compares each returned word against the expected solid background, either all zeros or all ones. Each mismatch is queued in a small fail log as an entry holding the address, the expected word and the observed word. A later diagnosis step can pop these entries and revisit only the failing cells. A start pulse launches the run. When the run ends, done rises and pass shows whether every read matched.

Top module: `march_rp_bist`

## Requirements
- R1: While reset is held and after it is released, done, pass, mem_we, mem_re, log_valid and log_overflow are all 0.
- R2: After start, exactly one memory operation is issued per cycle, in this element order. (1) Ascending: write 0x00 to every address. (2) Ascending: read expecting 0x00, then write all-ones, at each address. (3) Ascending: read expecting all-ones, write 0x00, then read-previous. (4) Descending: read expecting 0x00, write all-ones, then read-previous. (5) Descending: read expecting all-ones, then write 0x00. (6) Ascending: read expecting 0x00.
- R3: In element 3 the read-previous goes to address i-1 and expects 0x00. In element 4 it goes to address i+1 and expects all-ones. The read-previous is left out at the first address of each of these two elements (address 0 in element 3, address N-1 in element 4).
- R4: A run issues exactly 12N-2 operations for N = 2^AW addresses. The first operation comes in the cycle after start is sampled, and there are no idle cycles between operations.
- R5: The word returned on mem_rdata one cycle after a read is compared with that read's expected background. Any difference is a mismatch, and a run with a mismatch ends with pass = 0.
- R6: Each mismatch appends one fail-log entry, kept in detection order. log_valid is 1 while the log is non-empty, and log_addr, log_exp and log_obs show the oldest entry. A cycle with log_pop high removes that entry.
- R7: The log holds LOG_DEPTH entries. A mismatch found while the log is full is dropped, and it sets log_overflow, which stays set until the next accepted start.
- R8: done rises two cycles after the last operation and stays high until the next accepted start. pass is 1 only while done is high and the run found no mismatch.
- R9: A start pulse during a run is ignored, and the operation sequence continues unchanged.
- R10: A start accepted after done empties the log and clears log_overflow, the mismatch record and done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse that launches a test run |
| mem_addr | output | AW | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable |
| mem_wdata | output | DW | Memory write data (solid background) |
| mem_rdata | input | DW | Memory read data, one cycle after mem_re |
| done | output | 1 | Test finished |
| pass | output | 1 | Finished with no mismatch |
| log_pop | input | 1 | Remove the oldest fail-log entry |
| log_valid | output | 1 | Fail log non-empty |
| log_addr | output | AW | Address of oldest entry |
| log_exp | output | DW | Expected word of oldest entry |
| log_obs | output | DW | Observed word of oldest entry |
| log_overflow | output | 1 | A mismatch was dropped because the log was full |

## Verification
The assertions check local behaviour on every cycle. Every read-previous sits next to the write just before it and in the right direction. Written words are always solid. Overflow rises only on a mismatch that arrives while the log is full. A mismatch always clears pass, and done holds until a new start. The bench's runs are needed for the whole-sequence properties: the exact order of all 12N-2 operations, the timing of the end of the run, and the contents and order of the fail log. It checks these against a memory model with a neighbour-disturb fault and a stuck-at bit that forces the log to overflow.

// File: rtl/march_rp_bist.sv
module march_rp_bist #(
  parameter int AW        = 4,
  parameter int DW        = 8,
  parameter int LOG_DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic          mem_re,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          done,
  output logic          pass,
  input  logic          log_pop,
  output logic          log_valid,
  output logic [AW-1:0] log_addr,
  output logic [DW-1:0] log_exp,
  output logic [DW-1:0] log_obs,
  output logic          log_overflow
);

  localparam int PW = (LOG_DEPTH > 1) ? $clog2(LOG_DEPTH) : 1;
  localparam int CW = $clog2(LOG_DEPTH + 1);
  localparam int EW = AW + 2 * DW;
  localparam logic [AW-1:0] TOP = '1;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN, S_DONE} st_t;

  st_t           st;
  logic [2:0]    elem;
  logic [1:0]    op;
  logic [AW-1:0] idx;
  logic [1:0]    op_last;

  wire desc    = (elem == 3'd3) || (elem == 3'd4);
  wire is_wr   = (elem == 3'd0) || (op == 2'd1);
  wire is_rp   = (op == 2'd2);
  wire wval    = elem[0];
  wire rval    = ~elem[0];
  wire [AW-1:0] first = desc ? TOP : '0;
  wire [AW-1:0] last  = desc ? '0 : TOP;
  wire [2:0] elem_n   = elem + 3'd1;
  wire desc_n  = (elem_n == 3'd3) || (elem_n == 3'd4);
  wire skip_rp = (op == 2'd1) && (op_last == 2'd2) && (idx == first);
  wire addr_end = (op == op_last) || skip_rp;
  wire go      = start && (st == S_IDLE || st == S_DONE);

  always_comb begin
    case (elem)
      3'd1, 3'd4: op_last = 2'd1;
      3'd2, 3'd3: op_last = 2'd2;
      default:    op_last = 2'd0;
    endcase
  end

  assign mem_addr  = is_rp ? (desc ? idx + AW'(1) : idx - AW'(1)) : idx;
  assign mem_we    = (st == S_RUN) && is_wr;
  assign mem_re    = (st == S_RUN) && !is_wr;
  assign mem_wdata = {DW{wval}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      elem <= '0;
      op   <= '0;
      idx  <= '0;
    end else begin
      case (st)
        S_IDLE, S_DONE: if (go) begin
          st   <= S_RUN;
          elem <= '0;
          op   <= '0;
          idx  <= '0;
        end
        S_RUN: begin
          if (addr_end) begin
            op <= '0;
            if (idx == last) begin
              if (elem == 3'd5) st <= S_FIN;
              else begin
                elem <= elem_n;
                idx  <= desc_n ? TOP : '0;
              end
            end else begin
              idx <= desc ? idx - AW'(1) : idx + AW'(1);
            end
          end else begin
            op <= op + 2'd1;
          end
        end
        default: st <= S_DONE;
      endcase
    end
  end

  logic          chk_v;
  logic [DW-1:0] chk_exp;
  logic [AW-1:0] chk_addr;
  logic          err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_v    <= 1'b0;
      chk_exp  <= '0;
      chk_addr <= '0;
    end else begin
      chk_v    <= mem_re;
      chk_exp  <= {DW{is_rp ? wval : rval}};
      chk_addr <= mem_addr;
    end
  end

  wire mismatch = chk_v && (mem_rdata != chk_exp);

  always_ff @(posedge clk) begin
    if (!rst_n)        err <= 1'b0;
    else if (go)       err <= 1'b0;
    else if (mismatch) err <= 1'b1;
  end

  assign done = (st == S_DONE);
  assign pass = done && !err;

  logic [EW-1:0] ram [LOG_DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  wire full = (cnt == CW'(LOG_DEPTH));
  wire push = mismatch && !full;
  wire pop  = log_pop && log_valid;
  assign log_valid = (cnt != '0);

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(LOG_DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) ram[wp] <= {chk_addr, chk_exp, mem_rdata};
  end

  always_ff @(posedge clk) begin
    if (!rst_n || go) begin
      wp           <= '0;
      rp           <= '0;
      cnt          <= '0;
      log_overflow <= 1'b0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      case ({push, pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
      if (mismatch && full) log_overflow <= 1'b1;
    end
  end

  assign {log_addr, log_exp, log_obs} = ram[rp];

  assert_rp_neighbour_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && is_rp) |->
      ($past(mem_we) && mem_addr == (desc ? $past(mem_addr) + AW'(1) : $past(mem_addr) - AW'(1))));

  assert_solid_wdata_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_wdata == '0 || mem_wdata == '1));

  assert_overflow_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(log_overflow) |-> $past(mismatch && full));

  assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  assert_mismatch_fails_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |=> !pass);

endmodule

// File: tb/march_rp_bist_bench.sv
module march_rp_bist_bench;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int LD = 16;
  localparam int N  = 1 << AW;
  localparam int CLK_PERIOD = 10;
  localparam int AGG = 5;
  localparam int VIC = 4;

  logic clk = 0, rst_n = 0, start = 0, log_pop = 0;
  logic [AW-1:0] mem_addr, log_addr;
  logic mem_we, mem_re, done, pass, log_valid, log_overflow;
  logic [DW-1:0] mem_wdata, mem_rdata, log_exp, log_obs;

  always #(CLK_PERIOD / 2) clk = ~clk;

  march_rp_bist #(.AW(AW), .DW(DW), .LOG_DEPTH(LD)) u_march_rp_bist (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .pass(pass),
    .log_pop(log_pop), .log_valid(log_valid), .log_addr(log_addr),
    .log_exp(log_exp), .log_obs(log_obs), .log_overflow(log_overflow));

  typedef struct packed { logic we; logic [AW-1:0] a; logic [DW-1:0] d; } op_t;
  typedef struct packed { logic [AW-1:0] a; logic [DW-1:0] e; logic [DW-1:0] o; } ent_t;

  op_t  exp_q[$];
  ent_t fail_q[$];
  int checks = 0, fails = 0;
  int cyc = 0, opcnt = 0, first_cyc = 0, last_cyc = 0, done_cyc = 0, start_cyc = 0;
  bit got_done = 0, prev_done = 0, pend = 0;
  logic [AW-1:0] pend_a;
  logic [DW-1:0] pend_e;
  op_t cur;
  logic [DW-1:0] mem [N];
  logic [DW-1:0] stuck0 = '0;
  bit dist_en = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  // memory model: one-cycle read latency, optional neighbour disturb and stuck-at-0 bits
  always @(posedge clk) begin
    if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      if (dist_en && mem_addr == AW'(AGG)) mem[VIC] <= mem[VIC] ^ DW'(1);
    end
    if (mem_re) mem_rdata <= mem[mem_addr] & ~stuck0;
  end

  // monitor: pops the scoreboard and predicts fail-log entries
  always @(negedge clk) begin
    cyc++;
    if (pend) begin
      if (mem_rdata !== pend_e) fail_q.push_back('{pend_a, pend_e, mem_rdata});
      pend = 0;
    end
    if (mem_we || mem_re) begin
      if (exp_q.size() == 0) begin
        chk(0, "R2", "operation beyond sequence", {59'd0, mem_we, mem_addr}, 0);
      end else begin
        cur = exp_q.pop_front();
        chk(mem_we == cur.we && mem_addr == cur.a && (!cur.we || mem_wdata == cur.d),
            "R2 R3", "operation {we,addr,wdata}",
            {mem_we, mem_addr, mem_wdata}, {cur.we, cur.a, cur.d});
        if (!cur.we) begin pend = 1; pend_a = cur.a; pend_e = cur.d; end
      end
      opcnt++;
      if (opcnt == 1) first_cyc = cyc;
      last_cyc = cyc;
    end
    if (done && !prev_done) begin done_cyc = cyc; got_done = 1; end
    prev_done = done;
  end

  task automatic push_op(input bit we, input int a, input bit v);
    exp_q.push_back('{we, AW'(a), {DW{v}}});
  endtask

  // driver: expected sequence straight from the element list (R2, R3)
  task automatic build();
    for (int a = 0; a < N; a++) push_op(1, a, 0);
    for (int a = 0; a < N; a++) begin push_op(0, a, 0); push_op(1, a, 1); end
    for (int a = 0; a < N; a++) begin
      push_op(0, a, 1); push_op(1, a, 0);
      if (a > 0) push_op(0, a - 1, 0);
    end
    for (int a = N - 1; a >= 0; a--) begin
      push_op(0, a, 0); push_op(1, a, 1);
      if (a < N - 1) push_op(0, a + 1, 1);
    end
    for (int a = N - 1; a >= 0; a--) begin push_op(0, a, 1); push_op(1, a, 0); end
    for (int a = 0; a < N; a++) push_op(0, a, 0);
  endtask

  task automatic run(input bit mid_start);
    exp_q.delete(); fail_q.delete();
    opcnt = 0; got_done = 0;
    build();
    @(posedge clk); #1 start = 1; start_cyc = cyc;
    @(posedge clk); #1 start = 0;
    if (mid_start) begin
      repeat (40) @(posedge clk);
      #1 start = 1;   // R9: ignored while running
      @(posedge clk); #1 start = 0;
    end
    for (int i = 0; i < 4000 && !got_done; i++) @(negedge clk);
    #1;
    if (!got_done) begin
      checks++; fails++;
      $display("FAIL R8 watchdog: actual done 0 expected 1");
    end
    chk(opcnt == 12 * N - 2, "R4", "operation count", opcnt, 12 * N - 2);
    chk(first_cyc == start_cyc + 2, "R4", "first operation cycle", first_cyc, start_cyc + 2);
    chk(last_cyc - first_cyc + 1 == opcnt, "R4", "gap-free span", last_cyc - first_cyc + 1, opcnt);
    chk(exp_q.size() == 0, "R2", "operations left unissued", exp_q.size(), 0);
    chk(done_cyc - last_cyc == 2, "R8", "done delay after last operation", done_cyc - last_cyc, 2);
  endtask

  task automatic pop_check(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      chk(log_valid, "R6", "log_valid while entries remain", log_valid, 1);
      if (i < fail_q.size())
        chk({log_addr, log_exp, log_obs} == fail_q[i], "R6", "log entry {addr,exp,obs}",
            {log_addr, log_exp, log_obs}, fail_q[i]);
      log_pop = 1;
      @(posedge clk); #1 log_pop = 0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL global watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({done, pass, mem_we, mem_re, log_valid, log_overflow} == 6'b0, "R1", "outputs in reset",
        {done, pass, mem_we, mem_re, log_valid, log_overflow}, 0);
    @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    chk({done, pass, mem_we, mem_re, log_valid, log_overflow} == 6'b0, "R1", "outputs after reset",
        {done, pass, mem_we, mem_re, log_valid, log_overflow}, 0);

    // fault-free run
    run(0);
    chk(pass == 1, "R8", "pass on clean memory", pass, 1);
    chk(log_valid == 0, "R5", "log empty on clean memory", log_valid, 0);

    // neighbour disturb: writing AGG toggles bit 0 of VIC
    dist_en = 1;
    run(0);
    dist_en = 0;
    chk(pass == 0, "R5", "pass with disturb fault", pass, 0);
    chk(fail_q.size() == 4, "R3", "mismatches seen incl. read-previous", fail_q.size(), 4);
    pop_check(fail_q.size());
    @(negedge clk); #1;
    chk(log_valid == 0, "R6", "log empty after pops", log_valid, 0);
    chk(log_overflow == 0, "R7", "no overflow with few fails", log_overflow, 0);
    repeat (20) @(negedge clk);
    chk(done == 1, "R8", "done held while idle", done, 1);

    // stuck-at-0 on the top bit of every word overflows the log
    stuck0 = DW'(1) << (DW - 1);
    run(0);
    stuck0 = '0;
    chk(log_overflow == 1, "R7", "overflow flag", log_overflow, 1);
    chk(pass == 0, "R5", "pass with stuck bit", pass, 0);
    chk(fail_q.size() > LD, "R7", "more fails than log depth", fail_q.size(), LD + 1);
    pop_check(8);
    @(negedge clk); #1;
    chk(log_valid == 1, "R7", "log still holds entries", log_valid, 1);

    // restart with a stray start pulse mid-run
    run(1);
    chk(pass == 1, "R10", "pass after restart", pass, 1);
    chk(log_valid == 0, "R10", "log cleared by start", log_valid, 0);
    chk(log_overflow == 0, "R10", "overflow cleared by start", log_overflow, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule